// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags and Block Replay

This block buffers 36-bit words from a write clock domain into a read clock domain. The two clocks have no relationship to each other. Storage holds 512 words. Each side sees its own five-flag status vector, computed from its own view of the fill level. A request is sampled on the rising edge of its port clock. The port answers with an acknowledge one cycle later, and only if the access really took place. A producer or consumer on one side can therefore run right up to the full or empty boundary without racing the other side.

Each side owns two offset registers. The almost-full offset is counted down from the top of the buffer, and the almost-empty offset is counted up from zero. Each of the five flags on each side can be chosen on its own to follow the fill level combinationally, or to be registered on that side's clock.

The read side can mark its current position and later rewind to that mark any number of times. This replays a stored block of up to 512 words. While a mark is held, the write side counts the marked words as occupied, so they cannot be overwritten. Two of these blocks, wired in opposite directions, make a bidirectional buffer.

The read controller is a three-state machine:
- FOLLOW is the reset state. Normal reads happen here, and the pointer exported to the write side tracks the read pointer. A mark command moves it to HOLD.
- HOLD keeps the exported pointer frozen at the mark. Reads and rewinds are allowed. A release command moves it to CATCHUP.
- CATCHUP refuses reads. It walks the exported pointer up to the read pointer one step per read clock, then returns to FOLLOW.

Top module: `xclk_flag_fifo`

## Requirements
- R1: Words that are written are read out in the same order and unchanged. The read word appears on `rd_data` in the read-clock cycle that follows an accepted read request, and `rd_ack` is high in that same cycle.
- R2: A write request is accepted only while the write-side level is below 512. An accepted write raises `wr_ack` for the next write-clock cycle. A write request at level 512 stores nothing and gets no acknowledge.
- R3: A read request at a read-side level of zero does not advance the read position and gets no acknowledge.
- R4: After reset, each flag vector equals 5'b00011 (empty and almost-empty set) and both acknowledges are low. All four offset registers hold 8.
- R5: Flag bit positions are: [0] empty (level 0), [1] almost-empty, [2] half-full, [3] almost-full, [4] full (level 512).
- R6: Half-full (bit 2) is set exactly when the level is 256 or more.
- R7: Almost-full (bit 3) is set exactly when the level is at least 512 minus that side's almost-full offset.
- R8: Almost-empty (bit 1) is set exactly when the level is at most that side's almost-empty offset.
- R9: An offset register is loaded from `*_thr_val` on a clock edge where `*_thr_we` is high. `*_thr_sel` = 0 selects the almost-full offset and 1 selects the almost-empty offset.
- R10: When bit i of `*_flag_mode` is 1, flag i is registered: it reflects the level one clock of its side later than it would otherwise. When the bit is 0, flag i follows the level with no added register.
- R11: In FOLLOW, `rd_mark` captures the current read position and enters HOLD. In HOLD, `rd_retx` reloads the read position from the mark. This can be repeated, and each rewind replays the same words.
- R12: While in HOLD, the write side counts the level from the mark, so writes that would overwrite marked words are refused. After `rd_release`, reads are refused during CATCHUP. The space freed by reads made after the mark returns to the write side once CATCHUP ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_req | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| wr_ack | output | 1 | Previous write request was accepted |
| wr_thr_we | input | 1 | Load a write-side offset register |
| wr_thr_sel | input | 1 | 0 almost-full offset, 1 almost-empty offset |
| wr_thr_val | input | 10 | Offset value |
| wr_flag_mode | input | 5 | Per-flag select, 1 = registered |
| wr_flags | output | 5 | Write-side flag vector |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_req | input | 1 | Read request |
| rd_data | output | 36 | Word read |
| rd_ack | output | 1 | Previous read request was accepted; `rd_data` valid |
| rd_mark | input | 1 | Capture the read position (FOLLOW only) |
| rd_retx | input | 1 | Rewind to the mark (HOLD only) |
| rd_release | input | 1 | Leave HOLD |
| rd_thr_we | input | 1 | Load a read-side offset register |
| rd_thr_sel | input | 1 | 0 almost-full offset, 1 almost-empty offset |
| rd_thr_val | input | 10 | Offset value |
| rd_flag_mode | input | 5 | Per-flag select, 1 = registered |
| rd_flags | output | 5 | Read-side flag vector |

## Verification
The properties assume that both resets are asserted together and released before traffic starts. They also assume that `rd_mark`, `rd_retx` and `rd_release` are single-cycle pulses on the read clock, and that flag mode bits change only while the level is steady. The directed tasks drive every input on the falling edge of its own clock, in one of two ways:
- control pulses last exactly one read cycle;
- mode and offset changes are made only after both sides have had several cycles to settle.

Because of this, the cross-domain pointer views are never sampled mid-change by any check.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    typedef enum logic [1:0] {
        RS_FOLLOW  = 2'd0,
        RS_HOLD    = 2'd1,
        RS_CATCHUP = 2'd2
    } rd_state_e;

    localparam int FLG_EMPTY = 0;
    localparam int FLG_AE    = 1;
    localparam int FLG_HF    = 2;
    localparam int FLG_AF    = 3;
    localparam int FLG_FULL  = 4;
    localparam int NUM_FLAGS = 5;

    localparam int RESET_OFFSET = 8;

endpackage

// File: rtl/xfifo_gray_sync.sv
module xfifo_gray_sync #(
    parameter int W = 10
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);

    logic [W-1:0] src_gray_q;
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Source side: convert to Gray in a register so only one bit moves per step
    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            src_gray_q <= '0;
        end else begin
            src_gray_q <= src_bin ^ (src_bin >> 1);
        end
    end

    // Destination side: two-stage synchronizer
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= src_gray_q;
            stable_q <= meta_q;
        end
    end

    // Gray back to binary: bit i is the XOR of all Gray bits at and above i
    always_comb begin
        for (int i = 0; i < W; i++) begin
            dst_bin[i] = ^(stable_q >> i);
        end
    end

endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 9
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/xfifo_flags.sv
module xfifo_flags
    import xfifo_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W:0]      level,
    input  logic                 thr_we,
    input  logic                 thr_sel,
    input  logic [ADDR_W:0]      thr_val,
    input  logic [NUM_FLAGS-1:0] flag_mode,
    output logic [NUM_FLAGS-1:0] flags
);

    localparam int          PW      = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);
    localparam logic [PW-1:0] HALF_P  = PW'(1 << (ADDR_W - 1));
    localparam logic [PW-1:0] OFF_RST = PW'(RESET_OFFSET);

    logic [PW-1:0]        af_off_q;
    logic [PW-1:0]        ae_off_q;
    logic [NUM_FLAGS-1:0] live;
    logic [NUM_FLAGS-1:0] held_q;

    // Offset registers, loaded on this side's clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            af_off_q <= OFF_RST;
            ae_off_q <= OFF_RST;
        end else if (thr_we) begin
            if (thr_sel) begin
                ae_off_q <= thr_val;
            end else begin
                af_off_q <= thr_val;
            end
        end
    end

    // Flags decoded straight from the level
    always_comb begin
        live            = '0;
        live[FLG_EMPTY] = (level == '0);
        live[FLG_AE]    = (level <= ae_off_q);
        live[FLG_HF]    = (level >= HALF_P);
        live[FLG_AF]    = (level >= (DEPTH_P - af_off_q));
        live[FLG_FULL]  = (level == DEPTH_P);
    end

    // Registered copy of the same decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= NUM_FLAGS'((1 << FLG_EMPTY) | (1 << FLG_AE));
        end else begin
            held_q <= live;
        end
    end

    // Each flag picks its own timing
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag_sel
        assign flags[g] = flag_mode[g] ? held_q[g] : live[g];
    end

endmodule

// File: rtl/xfifo_rd_ctrl.sv
module xfifo_rd_ctrl
    import xfifo_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          mark_cmd,
    input  logic          retx_cmd,
    input  logic          release_cmd,
    input  logic [ADDR_W:0] wr_ptr_s,
    output logic [ADDR_W:0] rd_ptr,
    output logic [ADDR_W:0] exp_ptr,
    output logic [ADDR_W:0] mark_ptr,
    output logic [ADDR_W:0] rd_level,
    output rd_state_e     state,
    output logic          rd_fire
);

    localparam int PW = ADDR_W + 1;

    rd_state_e     state_q, state_nx;
    logic [PW-1:0] rd_q, rd_nx;
    logic [PW-1:0] exp_q, exp_nx;
    logic [PW-1:0] mark_q, mark_nx;
    logic          empty_now;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_FOLLOW;
            rd_q    <= '0;
            exp_q   <= '0;
            mark_q  <= '0;
        end else begin
            state_q <= state_nx;
            rd_q    <= rd_nx;
            exp_q   <= exp_nx;
            mark_q  <= mark_nx;
        end
    end

    assign rd_level  = wr_ptr_s - rd_q;
    assign empty_now = (rd_level == '0);

    // Next-state and output process
    always_comb begin
        state_nx = state_q;
        rd_nx    = rd_q;
        exp_nx   = exp_q;
        mark_nx  = mark_q;
        rd_fire  = 1'b0;
        unique case (state_q)
            RS_FOLLOW: begin
                rd_fire = rd_req && !empty_now;
                if (rd_fire) begin
                    rd_nx = rd_q + 1'b1;
                end
                if (mark_cmd) begin
                    // mark the position before any read in this cycle
                    mark_nx  = rd_q;
                    exp_nx   = rd_q;
                    state_nx = RS_HOLD;
                end else begin
                    exp_nx = rd_nx;
                end
            end
            RS_HOLD: begin
                if (retx_cmd) begin
                    rd_nx = mark_q;
                end else begin
                    rd_fire = rd_req && !empty_now;
                    if (rd_fire) begin
                        rd_nx = rd_q + 1'b1;
                    end
                end
                if (release_cmd) begin
                    state_nx = RS_CATCHUP;
                end
            end
            RS_CATCHUP: begin
                // exported pointer steps by one so its Gray code moves one bit
                if (exp_q == rd_q) begin
                    state_nx = RS_FOLLOW;
                end else begin
                    exp_nx = exp_q + 1'b1;
                end
            end
            default: begin
                state_nx = RS_FOLLOW;
            end
        endcase
    end

    assign rd_ptr   = rd_q;
    assign exp_ptr  = exp_q;
    assign mark_ptr = mark_q;
    assign state    = state_q;

endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo
    import xfifo_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 9
) (
    input  logic                 wr_clk,
    input  logic                 wr_rst_n,
    input  logic                 wr_req,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 wr_ack,
    input  logic                 wr_thr_we,
    input  logic                 wr_thr_sel,
    input  logic [ADDR_W:0]      wr_thr_val,
    input  logic [NUM_FLAGS-1:0] wr_flag_mode,
    output logic [NUM_FLAGS-1:0] wr_flags,
    input  logic                 rd_clk,
    input  logic                 rd_rst_n,
    input  logic                 rd_req,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_ack,
    input  logic                 rd_mark,
    input  logic                 rd_retx,
    input  logic                 rd_release,
    input  logic                 rd_thr_we,
    input  logic                 rd_thr_sel,
    input  logic [ADDR_W:0]      rd_thr_val,
    input  logic [NUM_FLAGS-1:0] rd_flag_mode,
    output logic [NUM_FLAGS-1:0] rd_flags
);

    localparam int            PW      = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

    logic [PW-1:0] wr_ptr_q;
    logic [PW-1:0] wr_ptr_in_rd;
    logic [PW-1:0] exp_in_wr;
    logic [PW-1:0] wr_level;
    logic          wr_fire;

    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] exp_ptr;
    logic [PW-1:0] mark_ptr;
    logic [PW-1:0] rd_level;
    logic          rd_fire;
    rd_state_e     rd_state;

    // ---------------- write side ----------------
    assign wr_level = wr_ptr_q - exp_in_wr;
    assign wr_fire  = wr_req && (wr_level != DEPTH_P);

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wr_ptr_q <= '0;
            wr_ack   <= 1'b0;
        end else begin
            wr_ack <= wr_fire;
            if (wr_fire) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
            end
        end
    end

    xfifo_flags #(.ADDR_W(ADDR_W)) u_wr_flags (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .level     (wr_level),
        .thr_we    (wr_thr_we),
        .thr_sel   (wr_thr_sel),
        .thr_val   (wr_thr_val),
        .flag_mode (wr_flag_mode),
        .flags     (wr_flags)
    );

    // ---------------- crossings ----------------
    xfifo_gray_sync #(.W(PW)) u_wr2rd (
        .src_clk   (wr_clk),
        .src_rst_n (wr_rst_n),
        .src_bin   (wr_ptr_q),
        .dst_clk   (rd_clk),
        .dst_rst_n (rd_rst_n),
        .dst_bin   (wr_ptr_in_rd)
    );

    xfifo_gray_sync #(.W(PW)) u_rd2wr (
        .src_clk   (rd_clk),
        .src_rst_n (rd_rst_n),
        .src_bin   (exp_ptr),
        .dst_clk   (wr_clk),
        .dst_rst_n (wr_rst_n),
        .dst_bin   (exp_in_wr)
    );

    // ---------------- storage ----------------
    xfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk  (wr_clk),
        .we    (wr_fire),
        .waddr (wr_ptr_q[ADDR_W-1:0]),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .re    (rd_fire),
        .raddr (rd_ptr[ADDR_W-1:0]),
        .rdata (rd_data)
    );

    // ---------------- read side ----------------
    xfifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd_ctrl (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .rd_req      (rd_req),
        .mark_cmd    (rd_mark),
        .retx_cmd    (rd_retx),
        .release_cmd (rd_release),
        .wr_ptr_s    (wr_ptr_in_rd),
        .rd_ptr      (rd_ptr),
        .exp_ptr     (exp_ptr),
        .mark_ptr    (mark_ptr),
        .rd_level    (rd_level),
        .state       (rd_state),
        .rd_fire     (rd_fire)
    );

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rd_ack <= 1'b0;
        end else begin
            rd_ack <= rd_fire;
        end
    end

    xfifo_flags #(.ADDR_W(ADDR_W)) u_rd_flags (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .level     (rd_level),
        .thr_we    (rd_thr_we),
        .thr_sel   (rd_thr_sel),
        .thr_val   (rd_thr_val),
        .flag_mode (rd_flag_mode),
        .flags     (rd_flags)
    );

endmodule

// File: rtl/xclk_flag_fifo_chk.sv
module xclk_flag_fifo_chk
    import xfifo_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input logic                 wr_clk,
    input logic                 wr_rst_n,
    input logic                 wr_req,
    input logic                 wr_ack,
    input logic [ADDR_W:0]      wr_level,
    input logic [NUM_FLAGS-1:0] wr_flags,
    input logic                 rd_clk,
    input logic                 rd_rst_n,
    input logic                 rd_req,
    input logic                 rd_ack,
    input logic [ADDR_W:0]      rd_level,
    input logic [NUM_FLAGS-1:0] rd_flags,
    input rd_state_e            rd_state,
    input logic [ADDR_W:0]      mark_ptr
);

    localparam logic [ADDR_W:0] DEPTH_P = (ADDR_W+1)'(1 << ADDR_W);

    p_ack_needs_req_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_ack |-> $past(wr_req));

    p_no_overflow_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_level <= DEPTH_P);

    p_full_refused_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_req && wr_level == DEPTH_P) |=> !wr_ack);

    p_empty_refused_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_req && rd_level == '0) |=> !rd_ack);

    p_wr_flags_excl_r5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !(wr_flags[FLG_FULL] && wr_flags[FLG_EMPTY]));

    p_rd_flags_excl_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !(rd_flags[FLG_FULL] && rd_flags[FLG_EMPTY]));

    p_mark_kept_r11: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_state != RS_FOLLOW) |=> $stable(mark_ptr));

    p_catchup_refuses_r12: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_state == RS_CATCHUP && rd_req) |=> !rd_ack);

endmodule

bind xclk_flag_fifo xclk_flag_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_req   (wr_req),
    .wr_ack   (wr_ack),
    .wr_level (wr_level),
    .wr_flags (wr_flags),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_req   (rd_req),
    .rd_ack   (rd_ack),
    .rd_level (rd_level),
    .rd_flags (rd_flags),
    .rd_state (rd_state),
    .mark_ptr (mark_ptr)
);

// File: tb/test_xclk_flag_fifo.sv
`timescale 1ns/1ps
module test_xclk_flag_fifo;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [35:0] wr_data = '0;
    logic        wr_ack;
    logic        wr_thr_we = 1'b0;
    logic        wr_thr_sel = 1'b0;
    logic [9:0]  wr_thr_val = '0;
    logic [4:0]  wr_flag_mode = '0;
    logic [4:0]  wr_flags;
    logic        rd_req = 1'b0;
    logic [35:0] rd_data;
    logic        rd_ack;
    logic        rd_mark = 1'b0;
    logic        rd_retx = 1'b0;
    logic        rd_release = 1'b0;
    logic        rd_thr_we = 1'b0;
    logic        rd_thr_sel = 1'b0;
    logic [9:0]  rd_thr_val = '0;
    logic [4:0]  rd_flag_mode = '0;
    logic [4:0]  rd_flags;

    int n_chk = 0;
    int n_bad = 0;
    int seq   = 0;
    logic [35:0] model_q[$];

    always #4   wr_clk = ~wr_clk;   // 125 MHz
    always #6.5 rd_clk = ~rd_clk;

    xclk_flag_fifo i_xclk_flag_fifo (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] word_of(input int n);
        return {4'hC, 32'(n * 32'h9E37 + 32'h51)};
    endfunction

    task automatic do_write(input logic [35:0] d, output logic ack);
        @(negedge wr_clk);
        wr_req  = 1'b1;
        wr_data = d;
        @(negedge wr_clk);
        ack    = wr_ack;
        wr_req = 1'b0;
    endtask

    task automatic do_read(output logic ack, output logic [35:0] d);
        @(negedge rd_clk);
        rd_req = 1'b1;
        @(negedge rd_clk);
        ack    = rd_ack;
        d      = rd_data;
        rd_req = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    task automatic fill(input int n, input string req);
        logic a;
        for (int i = 0; i < n; i++) begin
            logic [35:0] w;
            w = word_of(seq);
            seq++;
            do_write(w, a);
            chk(req, a, 1'b1);
            if (a) model_q.push_back(w);
        end
    endtask

    task automatic drain(input int n, input string req);
        logic a;
        logic [35:0] d;
        for (int i = 0; i < n; i++) begin
            do_read(a, d);
            chk(req, a, 1'b1);
            if (model_q.size() > 0) chk(req, d, model_q.pop_front());
        end
    endtask

    task automatic pulse_rd(input int which);
        @(negedge rd_clk);
        if (which == 0) rd_mark = 1'b1;
        if (which == 1) rd_retx = 1'b1;
        if (which == 2) rd_release = 1'b1;
        @(negedge rd_clk);
        rd_mark = 1'b0;
        rd_retx = 1'b0;
        rd_release = 1'b0;
    endtask

    task automatic t_reset();
        chk("R4 wr flags", wr_flags, 5'b00011);
        chk("R4 rd flags", rd_flags, 5'b00011);
        chk("R4 wr ack", wr_ack, 1'b0);
        chk("R4 rd ack", rd_ack, 1'b0);
    endtask

    task automatic t_order();
        logic a;
        logic [35:0] d;
        fill(5, "R1 write");
        settle();
        drain(5, "R1 order");
        do_read(a, d);
        chk("R3 read on empty no ack", a, 1'b0);
        settle();
        chk("R3 rd empty after refused read", rd_flags, 5'b00011);
    endtask

    task automatic t_flags();
        logic a;
        fill(8, "R2 fill");
        chk("R8 ae at 8", wr_flags[1], 1'b1);
        fill(1, "R2 fill");
        chk("R8 ae clear at 9", wr_flags[1], 1'b0);
        fill(246, "R2 fill");
        chk("R6 hf clear at 255", wr_flags[2], 1'b0);
        fill(1, "R2 fill");
        chk("R6 hf at 256", wr_flags[2], 1'b1);
        fill(247, "R2 fill");
        chk("R7 af clear at 503", wr_flags[3], 1'b0);
        fill(1, "R2 fill");
        chk("R7 af at 504", wr_flags[3], 1'b1);
        fill(7, "R2 fill");
        chk("R5 not full at 511", wr_flags[4], 1'b0);
        fill(1, "R2 fill");
        chk("R5 wr flags at 512", wr_flags, 5'b11100);
        do_write(36'hDEAD, a);
        chk("R2 write when full no ack", a, 1'b0);
        settle();
        chk("R5 rd flags at 512", rd_flags, 5'b11100);
        drain(512, "R2 full data intact");
        do_read(a, wr_data);
        chk("R3 empty after drain", a, 1'b0);
        settle();
        chk("R5 wr flags empty again", wr_flags, 5'b00011);
    endtask

    task automatic t_program();
        @(negedge wr_clk);
        wr_thr_we = 1'b1; wr_thr_sel = 1'b0; wr_thr_val = 10'd100;
        @(negedge wr_clk);
        wr_thr_we = 1'b0;
        @(negedge rd_clk);
        rd_thr_we = 1'b1; rd_thr_sel = 1'b1; rd_thr_val = 10'd20;
        @(negedge rd_clk);
        rd_thr_we = 1'b0;
        fill(20, "R9 fill");
        settle();
        chk("R9 rd ae at 20", rd_flags[1], 1'b1);
        fill(1, "R9 fill");
        settle();
        chk("R9 rd ae clear at 21", rd_flags[1], 1'b0);
        fill(390, "R9 fill");
        chk("R9 wr af clear at 411", wr_flags[3], 1'b0);
        fill(1, "R9 fill");
        chk("R9 wr af at 412", wr_flags[3], 1'b1);
        settle();
        drain(412, "R9 drain");
        settle();
    endtask

    task automatic t_mode();
        logic [35:0] w;
        wr_flag_mode = 5'b00001;
        settle();
        w = word_of(seq); seq++;
        @(negedge wr_clk);
        wr_req = 1'b1; wr_data = w;
        @(negedge wr_clk);
        wr_req = 1'b0;
        chk("R10 registered empty lags", wr_flags[0], 1'b1);
        @(negedge wr_clk);
        chk("R10 registered empty next clock", wr_flags[0], 1'b0);
        model_q.push_back(w);
        settle();
        drain(1, "R10 drain");
        wr_flag_mode = 5'b00000;
        settle();
        w = word_of(seq); seq++;
        @(negedge wr_clk);
        wr_req = 1'b1; wr_data = w;
        @(negedge wr_clk);
        wr_req = 1'b0;
        chk("R10 live empty at once", wr_flags[0], 1'b0);
        model_q.push_back(w);
        settle();
        drain(1, "R10 drain");
        settle();
    endtask

    task automatic t_retx();
        logic a;
        logic [35:0] d;
        logic [35:0] blk[6];
        fill(6, "R11 fill");
        for (int i = 0; i < 6; i++) blk[i] = model_q[i];
        settle();
        pulse_rd(0);
        for (int i = 0; i < 6; i++) begin
            do_read(a, d);
            chk("R11 first pass", d, blk[i]);
        end
        pulse_rd(1);
        for (int i = 0; i < 6; i++) begin
            do_read(a, d);
            chk("R11 replay", d, blk[i]);
        end
        pulse_rd(1);
        for (int i = 0; i < 3; i++) begin
            do_read(a, d);
            chk("R11 second replay", d, blk[i]);
        end
        settle();
        fill(506, "R12 fill behind mark");
        do_write(36'hBAD, a);
        chk("R12 overwrite refused", a, 1'b0);
        @(negedge rd_clk);
        rd_release = 1'b1;
        @(negedge rd_clk);
        rd_release = 1'b0;
        rd_req = 1'b1;
        @(negedge rd_clk);
        rd_req = 1'b0;
        chk("R12 read refused in catch-up", rd_ack, 1'b0);
        settle();
        chk("R12 space freed after release", wr_flags[4], 1'b0);
        for (int i = 0; i < 3; i++) void'(model_q.pop_front());
        fill(3, "R12 refill");
        do_write(36'hBAD, a);
        chk("R12 full again", a, 1'b0);
        settle();
        drain(512, "R12 drain order");
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #30;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        settle();
        t_reset();
        t_order();
        t_flags();
        t_program();
        t_mode();
        t_retx();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule